// File: doc/BRIEF.md
# I2C Target Transmitter with Host Handshake Flags

This block is the target side of an I2C bus. After reset it listens in receive mode. When a START appears it shifts in the first byte and compares the upper seven bits with its own 7-bit address. If they match, it answers the ninth clock with an acknowledge level that the host chose. If the last bit of that frame asks for a read, the block switches itself into transmit mode and shifts bytes out to the bus controller, most significant bit first.

The host side works through simple flags and strobes. The host writes a byte whenever the transmit-empty flag is set. Each written byte moves into the shifter as soon as the bus allows it, so steady writes give back-to-back bytes. When nothing is waiting after a byte, the block holds SCL low. It releases SCL only when the host writes more data, or when the host clears the direction bit and then does a dummy read of the receive register.

A STOP returns the block to idle receive mode from any state.

Top module: `i2cst_target`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `dir`, `tdre` and `tend` are 0 and `rx_data` is 8'h00.
- R2: Only the first byte after a START is compared with the address, using frame bits [7:1] against `OWN_ADDR`. On a mismatch the block never pulls SDA low during the ninth clock, stays in receive mode (`dir` = 0), and ignores later bytes until the next START.
- R3: On a match, the ninth-clock SDA level equals the `ack_lvl` value latched at the match (0 pulls SDA low, 1 leaves it released). The address byte is captured in `rx_data`.
- R4: A matched frame with bit 0 = 1 (read) sets `dir` and `tdre` to 1 with no host action.
- R5: Data bits come out MSB first. SDA changes only while SCL is low. `tx_wr` clears `tdre`. Moving the byte into the shifter sets `tdre` again, so a byte written during a transfer goes out with no extra SCL hold.
- R6: In transmit mode, after the ninth clock with no byte waiting, the block holds SCL low and leaves SDA released until a byte is written.
- R7: `tend` rises on the ninth SCL rising edge of a data byte when no further byte is waiting. `tend_clr` clears it.
- R8: A held SCL is released only when `dir` is 0 and the host pulses `rx_rd`; clearing `dir` alone keeps it held. `tdre_clr` clears `tdre`.
- R9: A NACK (SDA high at the ninth rising edge) ends the transfer. SCL and SDA stay released until the next START or STOP.
- R10: A STOP (SDA rising while SCL is high) returns the block to idle with `dir` = 0 and both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level as seen on the bus |
| sda_i | input | 1 | SDA line level as seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (clock hold) |
| sda_oe | output | 1 | 1 pulls SDA low |
| ack_lvl | input | 1 | Level to present on SDA in the address acknowledge slot |
| tx_wr | input | 1 | One-cycle strobe that writes `tx_data` into the transmit register |
| tx_data | input | 8 | Byte to transmit |
| tend_clr | input | 1 | Strobe that clears `tend` |
| tdre_clr | input | 1 | Strobe that clears `tdre` |
| dir_clr | input | 1 | Strobe that clears `dir` |
| rx_rd | input | 1 | Dummy-read strobe of the receive register |
| dir | output | 1 | 1 = transmit mode, 0 = receive mode |
| tdre | output | 1 | Transmit register empty |
| tend | output | 1 | Transmission ended with nothing left to send |
| rx_data | output | 8 | Last matched address byte |

## Verification
The block sees a bus edge two synchronizer flops plus one compare stage after the line moves. It therefore changes `sda_oe` or `scl_oe` in the third clock after an SCL edge, and changes flags on that same edge. A host strobe changes its flag one cycle later, and a byte written while the block holds SCL reaches the shifter two cycles after `tx_wr`, releasing SCL at that moment. The bench holds every bus phase for twenty cycles and samples only on falling clock edges, several cycles past each of these points. It also compares the SDA drive against the SCL line on every clock.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // receive mode, waiting for START
    ST_ADDR,   // shifting in the address frame
    ST_AWAIT,  // matched, waiting for SCL low to present ack
    ST_AACK,   // driving the ack slot
    ST_TLOAD,  // transmit: holding SCL until a byte is ready
    ST_TBIT,   // transmit: shifting out data bits
    ST_TACK,   // transmit: sampling the controller's ack
    ST_PARK    // finished or released: lines free until START/STOP
  } st_t;

  // Upper seven bits of a frame name the target
  function automatic logic addr_hit(input logic [7:0] frame, input logic [6:0] own);
    return frame[7:1] == own;
  endfunction

  // Next MSB-first shifter value
  function automatic logic [7:0] shift_msb(input logic [7:0] v);
    return {v[6:0], 1'b0};
  endfunction

endpackage

// File: rtl/i2cst_sync.sv
module i2cst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cst_edges.sv
module i2cst_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cst_target.sv
module i2cst_target
  import i2cst_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR    = 7'h3A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       ack_lvl,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  input  logic       tend_clr,
  input  logic       tdre_clr,
  input  logic       dir_clr,
  input  logic       rx_rd,
  output logic       dir,
  output logic       tdre,
  output logic       tend,
  output logic [7:0] rx_data
);
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2cst_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (.clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  i2cst_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (.clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  i2cst_edges u_edges (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  st_t              state;
  logic [7:0]       shreg, txbuf;
  logic [CNT_W-1:0] bitcnt;
  logic             buf_full, nack, ack_bit;

  // Named internal events for the checker
  logic [7:0] frame;
  logic       hit_ev, tend_set;
  assign frame    = {shreg[6:0], sda_s};
  assign hit_ev   = (state == ST_ADDR) && scl_rise && (bitcnt == LAST_BIT)
                    && addr_hit(frame, OWN_ADDR);
  assign tend_set = (state == ST_TACK) && scl_rise && !buf_full;

  assign scl_oe = (state == ST_TLOAD);
  assign sda_oe = ((state == ST_AACK) && !ack_bit) ||
                  ((state == ST_TBIT) && !shreg[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      txbuf    <= '0;
      bitcnt   <= '0;
      buf_full <= 1'b0;
      nack     <= 1'b0;
      ack_bit  <= 1'b0;
      dir      <= 1'b0;
      tdre     <= 1'b0;
      tend     <= 1'b0;
      rx_data  <= '0;
    end else begin
      // host strobes
      if (tx_wr) begin
        txbuf    <= tx_data;
        buf_full <= 1'b1;
        tdre     <= 1'b0;
      end
      if (tend_clr) tend <= 1'b0;
      if (tdre_clr) tdre <= 1'b0;
      if (dir_clr)  dir  <= 1'b0;

      // bus side
      if (stop_ev) begin
        state    <= ST_IDLE;
        dir      <= 1'b0;
        buf_full <= 1'b0;
      end else if (start_ev) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: if (scl_rise) begin
            shreg  <= frame;
            bitcnt <= bitcnt + CNT_ONE;
            if (bitcnt == LAST_BIT) begin
              if (hit_ev) begin
                rx_data <= frame;
                ack_bit <= ack_lvl;
                state   <= ST_AWAIT;
                if (frame[0]) begin
                  dir      <= 1'b1;
                  tdre     <= 1'b1;
                  buf_full <= 1'b0;
                end
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AWAIT: if (scl_fall) state <= ST_AACK;
          ST_AACK:  if (scl_fall) state <= rx_data[0] ? ST_TLOAD : ST_IDLE;
          ST_TLOAD: begin
            if (!dir && rx_rd) begin
              state <= ST_PARK;
            end else if (buf_full) begin
              shreg    <= txbuf;
              buf_full <= 1'b0;
              tdre     <= 1'b1;
              bitcnt   <= '0;
              state    <= ST_TBIT;
            end
          end
          ST_TBIT: if (scl_fall) begin
            shreg  <= shift_msb(shreg);
            bitcnt <= bitcnt + CNT_ONE;
            if (bitcnt == LAST_BIT) state <= ST_TACK;
          end
          ST_TACK: begin
            if (scl_rise) begin
              nack <= sda_s;
              if (tend_set) tend <= 1'b1;
            end
            if (scl_fall) state <= nack ? ST_PARK : ST_TLOAD;
          end
          ST_PARK: ;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cst_checker.sv
module i2cst_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_rise,
  input logic stop_ev,
  input logic hit_ev,
  input logic dir,
  input logic tdre,
  input logic tend,
  input logic scl_oe,
  input logic sda_oe
);
  // R10: a STOP frees both lines and drops transmit mode
  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!scl_oe && !sda_oe && !dir));

  // R5: SDA drive holds still while synchronized SCL stays high
  assert_sda_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R4: entering transmit mode comes with the empty flag
  assert_read_sets_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir) |-> tdre);

  // R2: transmit mode is entered only from an address match
  assert_dir_from_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir) |-> $past(hit_ev));

  // R7: end flag rises only on an SCL rising edge
  assert_tend_on_ack_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend) |-> $past(scl_rise));

  // R6: while holding SCL the block leaves SDA free
  assert_hold_keeps_sda_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> !sda_oe);
endmodule

bind i2cst_target i2cst_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_rise(scl_rise),
  .stop_ev(stop_ev), .hit_ev(hit_ev), .dir(dir), .tdre(tdre),
  .tend(tend), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/tb_i2cst_target.sv
`timescale 1ns/1ps
module tb_i2cst_target;
  localparam logic [6:0] OWN = 7'h3A;
  localparam int H = 20;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic ack_lvl = 1'b0, tx_wr = 1'b0, tend_clr = 1'b0, tdre_clr = 1'b0;
  logic dir_clr = 1'b0, rx_rd = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic scl_oe, sda_oe, dir, tdre, tend;
  logic [7:0] rx_data;
  logic scl_line, sda_line;
  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  i2cst_target #(.OWN_ADDR(OWN)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .ack_lvl(ack_lvl),
    .tx_wr(tx_wr), .tx_data(tx_data), .tend_clr(tend_clr),
    .tdre_clr(tdre_clr), .dir_clr(dir_clr), .rx_rd(rx_rd),
    .dir(dir), .tdre(tdre), .tend(tend), .rx_data(rx_data)
  );

  int tests = 0, fails = 0, cyc = 0, viol = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Every-clock reference rule: target SDA drive never moves while SCL line stays high (R5)
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_line && prev_scl && (sda_oe != prev_oe)) viol++;
    prev_scl <= scl_line;
    prev_oe  <= sda_oe;
  end

  always @(posedge clk) begin
    cyc++;
    if (!done && cyc > WD_LIMIT) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic host_write(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic host_op(input int which);
    @(negedge clk);
    case (which)
      0: tend_clr = 1'b1;
      1: tdre_clr = 1'b1;
      2: dir_clr  = 1'b1;
      default: rx_rd = 1'b1;
    endcase
    @(negedge clk);
    tend_clr = 1'b0; tdre_clr = 1'b0; dir_clr = 1'b0; rx_rd = 1'b0;
  endtask

  task automatic clock_bit(input logic send, output logic got, output int waited);
    m_sda_low = !send;
    waitc(H);
    m_scl_low = 1'b0;
    waited = 0;
    while (!scl_line) begin @(negedge clk); waited++; end
    waitc(H/2);
    got = sda_line;
    waitc(H/2);
    m_scl_low = 1'b1;
    waitc(2);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; waitc(H);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    waitc(H);
    m_sda_low = 1'b1; waitc(H);
    m_scl_low = 1'b1; waitc(H);
  endtask

  task automatic bus_stop();
    m_scl_low = 1'b1; waitc(H);
    m_sda_low = 1'b1; waitc(H);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    waitc(H);
    m_sda_low = 1'b0; waitc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic g; int w;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], g, w);
    clock_bit(1'b1, ack, w);
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b, output int w_first);
    logic g; int w;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, g, w);
      if (i == 7) w_first = w;
      b[i] = g;
    end
    clock_bit(mack, g, w);
  endtask

  initial begin
    logic ack, g;
    logic [7:0] rb;
    int w;

    waitc(6);
    rst_n = 1'b1;
    waitc(3);
    // R1 reset state
    chk("R1", "scl_oe", scl_oe, 0);
    chk("R1", "sda_oe", sda_oe, 0);
    chk("R1", "dir", dir, 0);
    chk("R1", "tdre", tdre, 0);
    chk("R1", "tend", tend, 0);
    chk("R1", "rx_data", rx_data, 0);

    // R2 foreign address, then own address without a fresh START
    bus_start();
    send_byte({7'h11, 1'b1}, ack);
    chk("R2", "ack on foreign address", ack, 1);
    chk("R2", "dir after foreign address", dir, 0);
    send_byte({OWN, 1'b1}, ack);
    chk("R2", "ack on second frame", ack, 1);
    chk("R2", "dir after second frame", dir, 0);
    bus_stop();

    // R3 write frame, ack level 0 then 1
    ack_lvl = 1'b0;
    bus_start();
    send_byte({OWN, 1'b0}, ack);
    chk("R3", "ack slot with level 0", ack, 0);
    chk("R3", "rx_data address byte", rx_data, {OWN, 1'b0});
    chk("R3", "dir after write frame", dir, 0);
    bus_stop();
    ack_lvl = 1'b1;
    bus_start();
    send_byte({OWN, 1'b0}, ack);
    chk("R3", "ack slot with level 1", ack, 1);
    bus_stop();
    ack_lvl = 1'b0;

    // R4 read frame
    bus_start();
    send_byte({OWN, 1'b1}, ack);
    chk("R3", "ack on read frame", ack, 0);
    chk("R4", "dir after read match", dir, 1);
    chk("R4", "tdre after read match", tdre, 1);

    // R6 clock hold with nothing written
    m_scl_low = 1'b0;
    waitc(100);
    chk("R6", "SCL held low with no data", scl_line, 0);
    chk("R6", "SDA free during hold", sda_oe, 0);

    // R5 load sets tdre, write clears it
    host_write(8'hA5);
    waitc(5);
    chk("R5", "tdre after byte moved to shifter", tdre, 1);
    host_write(8'h3C);
    waitc(2);
    chk("R5", "tdre after host write", tdre, 0);
    read_byte(1'b0, rb, w);
    chk("R5", "first byte MSB first", rb, 8'hA5);
    waitc(6);
    chk("R5", "tdre after second load", tdre, 1);
    read_byte(1'b0, rb, w);
    chk("R5", "second byte value", rb, 8'h3C);
    chk("R5", "no hold before queued byte", (w < 3) ? 1 : 0, 1);

    // R7 end flag and clear
    chk("R7", "tend after last byte", tend, 1);
    host_op(0);
    waitc(2);
    chk("R7", "tend after clear", tend, 0);

    // R8 release sequence
    m_scl_low = 1'b0;
    waitc(50);
    chk("R6", "SCL held after last byte", scl_line, 0);
    host_op(2);
    waitc(50);
    chk("R8", "SCL still held with dir cleared only", scl_line, 0);
    host_op(3);
    waitc(10);
    chk("R8", "SCL released after dummy read", scl_line, 1);
    host_op(1);
    waitc(2);
    chk("R8", "tdre after clear", tdre, 0);
    bus_stop();
    chk("R10", "lines free after stop", {scl_oe, sda_oe}, 0);

    // R9 NACK ends transfer, R10 stop drops dir
    bus_start();
    send_byte({OWN, 1'b1}, ack);
    host_write(8'h81);
    read_byte(1'b1, rb, w);
    chk("R9", "byte before NACK", rb, 8'h81);
    chk("R7", "tend after NACKed byte", tend, 1);
    clock_bit(1'b1, g, w);
    chk("R9", "SDA released after NACK", g, 1);
    chk("R9", "no clock hold after NACK", (w < 3) ? 1 : 0, 1);
    chk("R9", "dir kept until stop", dir, 1);
    host_op(0);
    host_op(1);
    bus_stop();
    waitc(3);
    chk("R10", "dir after stop", dir, 0);
    chk("R10", "scl_oe after stop", scl_oe, 0);
    chk("R10", "sda_oe after stop", sda_oe, 0);

    chk("R5", "SDA changes while SCL high", viol, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule